// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Age-Ranked Replacement

This block caches page-number translations for a 16-bit virtual address space split into 256-byte pages. A lookup presents a virtual address and a read/write flag; all eight entries are compared against the upper byte of the address in the same cycle. The low byte passes through untranslated. On a hit the block returns the physical address and a protection fault if the entry's permissions forbid the access.

On a miss the block records the request and raises a pending flag. It then waits for a refill carrying a physical page number, permission bits and a present flag. A present refill is installed. A free entry is used if one exists; otherwise the least recently used entry is replaced. When a live entry is replaced, its page numbers and dirty bit are reported for one cycle so that the page can be written back. A refill that is not present raises a page fault and installs nothing. Writing the page-table base clears every entry.

Recency is kept as a 3-bit age per entry. Age 0 marks the most recent entry and age 7 the oldest. Free entries sit at age 7 and do not age.

Top module: `tlbAgeLru`

## Requirements
- R1: The physical address is {page number from the entry or refill, virtual address bits [7:0]}. The offset byte is not translated, and on a refill it is the offset captured with the missed lookup.
- R2: When lookupValid is high and lookupReady is high, hit goes high in the same cycle exactly when a valid entry's tag equals lookupVaddr[15:8]. Otherwise it is a miss.
- R3: An accepted access to an entry of age k sets that entry to age 0. Each other valid entry younger than k ages by one, and all other ages are kept. A faulting hit changes no age. The effect is seen through the order in which entries are later evicted.
- R4: While any entry is invalid, a present refill goes into a free entry and evictValid stays low.
- R5: When all entries are valid, a present refill replaces the age-7 entry. In the cycle after the refill, evictValid is high for exactly one cycle, with the victim's VPN, PPN and dirty bit.
- R6: An accepted write access sets the entry's dirty bit, whether it hits or is installed by a refill. An entry written only by reads, or by writes that fault, is evicted clean.
- R7: protFault is high when the permission needed is clear: canRead for a read (lookupWrite=0), canWrite for a write (lookupWrite=1). This applies both to a hit and to a present refill. A faulting hit leaves the age and dirty state unchanged.
- R8: A refill with refillPresent=0 raises pageFault in that cycle, installs nothing and ends the pending miss.
- R9: After a miss, missPending is high and lookupReady is low from the next cycle until a refill is accepted. Lookups presented during that time give no hit and are ignored.
- R10: A baseWrite pulse invalidates every entry and cancels a pending miss. Later lookups miss, and a refill with no miss pending has no effect.
- R11: A synchronous reset (rst high) leaves all entries invalid, missPending low and evictValid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookupValid | input | 1 | A lookup is presented |
| lookupVaddr | input | 16 | Virtual address |
| lookupWrite | input | 1 | 1 = write access, 0 = read access |
| lookupReady | output | 1 | Lookups are accepted (no miss pending) |
| hit | output | 1 | Lookup matched a valid entry |
| paddr | output | 16 | Physical address for a hit or a present refill |
| protFault | output | 1 | Access forbidden by the permission bits |
| pageFault | output | 1 | Refill reported the page as not present |
| missPending | output | 1 | Waiting for a refill |
| refillValid | input | 1 | A refill is presented |
| refillPpn | input | 8 | Physical page number to install |
| refillCanRead | input | 1 | Read permission of the refilled page |
| refillCanWrite | input | 1 | Write permission of the refilled page |
| refillPresent | input | 1 | Page is resident; 0 signals a page fault |
| baseWrite | input | 1 | Page-table base is written; flush all entries |
| evictValid | output | 1 | One-cycle pulse: a valid entry was replaced |
| evictVpn | output | 8 | Victim virtual page number |
| evictPpn | output | 8 | Victim physical page number |
| evictDirty | output | 1 | Victim dirty bit |

## Verification
A long pseudo-random access stream runs over a pool of twelve page numbers competing for eight entries. A reference model computes the expected hits, faults, physical addresses and victims. A wrong age update would evict the wrong page, and filling before free entries are used would raise spurious eviction pulses. Directed cases cover the following:
- A lookup during a pending miss. A design that accepted it would hit or overwrite the captured offset.
- A flush during a pending miss, followed by a stray refill. A design that ignored the flush would still install the page.
- Faulting hits and not-present refills. A design that handled them wrongly would age or dirty entries, or install pages that were never granted.

// File: rtl/tlbPkg.sv
package tlbPkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } tlbStateT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic lookupPhase;   // a lookup is being evaluated this cycle
    logic refillPhase;   // a refill is being evaluated this cycle
    logic hitUpdate;     // accepted hit: age and dirty update
    logic missCapture;   // record the missed request
    logic refillInstall; // write refill into victim entry
    logic flushAll;      // invalidate everything
  } tlbStrobeT;

endpackage

// File: rtl/tlbControl.sv
module tlbControl
  import tlbPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lookupValid,
  input  logic      refillValid,
  input  logic      refillPresent,
  input  logic      baseWrite,
  input  logic      matchAny,
  input  logic      hitAllowed,
  output tlbStrobeT strobe,
  output logic      missPending
);

  tlbStateT stateQ, stateD;

  always_comb begin
    strobe               = '0;
    strobe.lookupPhase   = (stateQ == ST_IDLE) && lookupValid;
    strobe.refillPhase   = (stateQ == ST_WAIT) && refillValid;
    strobe.flushAll      = baseWrite;
    strobe.hitUpdate     = strobe.lookupPhase && matchAny && hitAllowed && !baseWrite;
    strobe.missCapture   = strobe.lookupPhase && !matchAny && !baseWrite;
    strobe.refillInstall = strobe.refillPhase && refillPresent && !baseWrite;
  end

  always_comb begin
    stateD = stateQ;
    if (baseWrite) begin
      stateD = ST_IDLE;
    end else if (strobe.missCapture) begin
      stateD = ST_WAIT;
    end else if (strobe.refillPhase) begin
      stateD = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign missPending = (stateQ == ST_WAIT);

endmodule

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int VA_W    = 16,
  parameter int PA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tlbStrobeT         strobe,
  input  logic [VA_W-1:0]   lookupVaddr,
  input  logic              lookupWrite,
  input  logic [PA_W-OFF_W-1:0] refillPpn,
  input  logic              refillCanRead,
  input  logic              refillCanWrite,
  input  logic              refillPresent,
  output logic              matchAny,
  output logic              hitAllowed,
  output logic              hit,
  output logic [PA_W-1:0]   paddr,
  output logic              protFault,
  output logic              pageFault,
  output logic              evictValid,
  output logic [VA_W-OFF_W-1:0] evictVpn,
  output logic [PA_W-OFF_W-1:0] evictPpn,
  output logic              evictDirty
);

  localparam int VPN_W    = VA_W - OFF_W;
  localparam int PPN_W    = PA_W - OFF_W;
  localparam int RANK_W   = $clog2(ENTRIES);
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(ENTRIES - 1);

  // entry storage
  logic [VPN_W-1:0]  tagQ   [ENTRIES];
  logic [PPN_W-1:0]  ppnQ   [ENTRIES];
  logic [RANK_W-1:0] rankQ  [ENTRIES];
  logic [ENTRIES-1:0] validQ, dirtyQ, canRdQ, canWrQ;

  // captured miss
  logic [VPN_W-1:0] pendVpnQ;
  logic [OFF_W-1:0] pendOffQ;
  logic             pendWriteQ;

  logic [VPN_W-1:0] lookupVpn;
  logic [OFF_W-1:0] lookupOff;
  assign lookupVpn = lookupVaddr[VA_W-1:OFF_W];
  assign lookupOff = lookupVaddr[OFF_W-1:0];

  // tag compare, one comparator per entry
  logic [ENTRIES-1:0] matchVec;
  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_match
      assign matchVec[gi] = validQ[gi] && (tagQ[gi] == lookupVpn);
    end
  endgenerate

  // one-hot mux of the matching entry
  logic [PPN_W-1:0]  hitPpn;
  logic [RANK_W-1:0] hitRank;
  logic              hitRd, hitWr;
  always_comb begin
    hitPpn  = '0;
    hitRank = '0;
    hitRd   = 1'b0;
    hitWr   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      hitPpn  = hitPpn  | (ppnQ[i]  & {PPN_W{matchVec[i]}});
      hitRank = hitRank | (rankQ[i] & {RANK_W{matchVec[i]}});
      hitRd   = hitRd   | (canRdQ[i] & matchVec[i]);
      hitWr   = hitWr   | (canWrQ[i] & matchVec[i]);
    end
  end

  assign matchAny   = |matchVec;
  assign hitAllowed = lookupWrite ? hitWr : hitRd;

  // victim selection: lowest free entry, else the oldest valid entry
  logic             anyFree;
  logic [IDX_W-1:0] freeIdx, oldIdx, victimIdx;
  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    oldIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
      if (validQ[i] && (rankQ[i] == OLDEST)) begin
        oldIdx = IDX_W'(i);
      end
    end
    victimIdx = anyFree ? freeIdx : oldIdx;
  end

  logic [ENTRIES-1:0] victimSel;
  always_comb begin
    victimSel = '0;
    victimSel[victimIdx] = 1'b1;
  end

  // age update control
  logic [ENTRIES-1:0] touchSel;
  logic [RANK_W-1:0]  touchRank;
  logic               ageStep;
  assign ageStep   = strobe.hitUpdate || strobe.refillInstall;
  assign touchSel  = strobe.hitUpdate ? matchVec :
                     (strobe.refillInstall ? victimSel : '0);
  assign touchRank = strobe.hitUpdate ? hitRank : rankQ[victimIdx];

  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst || strobe.flushAll) begin
          validQ[gi] <= 1'b0;
          dirtyQ[gi] <= 1'b0;
          rankQ[gi]  <= OLDEST;
        end else begin
          if (touchSel[gi]) begin
            rankQ[gi] <= '0;
          end else if (ageStep && validQ[gi] && (rankQ[gi] < touchRank)) begin
            rankQ[gi] <= rankQ[gi] + 1'b1;
          end
          if (strobe.refillInstall && victimSel[gi]) begin
            tagQ[gi]   <= pendVpnQ;
            ppnQ[gi]   <= refillPpn;
            canRdQ[gi] <= refillCanRead;
            canWrQ[gi] <= refillCanWrite;
            validQ[gi] <= 1'b1;
            dirtyQ[gi] <= pendWriteQ && refillCanWrite;
          end else if (strobe.hitUpdate && matchVec[gi] && lookupWrite) begin
            dirtyQ[gi] <= 1'b1;
          end
        end
      end
    end
  endgenerate

  // miss capture
  always_ff @(posedge clk) begin
    if (rst) begin
      pendVpnQ   <= '0;
      pendOffQ   <= '0;
      pendWriteQ <= 1'b0;
    end else if (strobe.missCapture) begin
      pendVpnQ   <= lookupVpn;
      pendOffQ   <= lookupOff;
      pendWriteQ <= lookupWrite;
    end
  end

  // eviction report, one cycle after the replacing refill
  always_ff @(posedge clk) begin
    if (rst) begin
      evictValid <= 1'b0;
      evictVpn   <= '0;
      evictPpn   <= '0;
      evictDirty <= 1'b0;
    end else begin
      evictValid <= strobe.refillInstall && !anyFree;
      if (strobe.refillInstall) begin
        evictVpn   <= tagQ[victimIdx];
        evictPpn   <= ppnQ[victimIdx];
        evictDirty <= dirtyQ[victimIdx];
      end
    end
  end

  // response
  logic refillAllowed, refillShown;
  assign refillAllowed = pendWriteQ ? refillCanWrite : refillCanRead;
  assign refillShown   = strobe.refillPhase && refillPresent;

  assign hit       = strobe.lookupPhase && matchAny;
  assign pageFault = strobe.refillPhase && !refillPresent;
  assign protFault = (hit && !hitAllowed) || (refillShown && !refillAllowed);

  always_comb begin
    if (hit)              paddr = {hitPpn, lookupOff};
    else if (refillShown) paddr = {refillPpn, pendOffQ};
    else                  paddr = '0;
  end

endmodule

// File: rtl/tlbAgeLru.sv
module tlbAgeLru
  import tlbPkg::*;
#(
  parameter int VA_W    = 16,
  parameter int PA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int ENTRIES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lookupValid,
  input  logic [VA_W-1:0]       lookupVaddr,
  input  logic                  lookupWrite,
  output logic                  lookupReady,
  output logic                  hit,
  output logic [PA_W-1:0]       paddr,
  output logic                  protFault,
  output logic                  pageFault,
  output logic                  missPending,
  input  logic                  refillValid,
  input  logic [PA_W-OFF_W-1:0] refillPpn,
  input  logic                  refillCanRead,
  input  logic                  refillCanWrite,
  input  logic                  refillPresent,
  input  logic                  baseWrite,
  output logic                  evictValid,
  output logic [VA_W-OFF_W-1:0] evictVpn,
  output logic [PA_W-OFF_W-1:0] evictPpn,
  output logic                  evictDirty
);

  tlbStrobeT strobe;
  logic      matchAny, hitAllowed;

  tlbControl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .lookupValid  (lookupValid),
    .refillValid  (refillValid),
    .refillPresent(refillPresent),
    .baseWrite    (baseWrite),
    .matchAny     (matchAny),
    .hitAllowed   (hitAllowed),
    .strobe       (strobe),
    .missPending  (missPending)
  );

  tlbDatapath #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .OFF_W  (OFF_W),
    .ENTRIES(ENTRIES)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .lookupVaddr   (lookupVaddr),
    .lookupWrite   (lookupWrite),
    .refillPpn     (refillPpn),
    .refillCanRead (refillCanRead),
    .refillCanWrite(refillCanWrite),
    .refillPresent (refillPresent),
    .matchAny      (matchAny),
    .hitAllowed    (hitAllowed),
    .hit           (hit),
    .paddr         (paddr),
    .protFault     (protFault),
    .pageFault     (pageFault),
    .evictValid    (evictValid),
    .evictVpn      (evictVpn),
    .evictPpn      (evictPpn),
    .evictDirty    (evictDirty)
  );

  assign lookupReady = !missPending;

endmodule

// File: rtl/tlbChecker.sv
module tlbChecker #(
  parameter int VA_W  = 16,
  parameter int PA_W  = 16,
  parameter int OFF_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            lookupValid,
  input logic [VA_W-1:0] lookupVaddr,
  input logic            lookupReady,
  input logic            hit,
  input logic [PA_W-1:0] paddr,
  input logic            protFault,
  input logic            pageFault,
  input logic            missPending,
  input logic            refillValid,
  input logic            baseWrite,
  input logic            evictValid
);

  assert_offset_passthrough_R1: assert property (@(posedge clk) disable iff (rst)
    hit |-> (paddr[OFF_W-1:0] == lookupVaddr[OFF_W-1:0]));

  assert_miss_sets_pending_R9: assert property (@(posedge clk) disable iff (rst)
    (lookupValid && lookupReady && !hit && !baseWrite) |=> missPending);

  assert_no_hit_while_pending_R9: assert property (@(posedge clk) disable iff (rst)
    missPending |-> !hit);

  assert_evict_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    evictValid |=> !evictValid);

  assert_evict_follows_refill_R5: assert property (@(posedge clk) disable iff (rst)
    evictValid |-> $past(refillValid && missPending && !baseWrite));

  assert_faults_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(protFault && pageFault));

  assert_page_fault_ends_miss_R8: assert property (@(posedge clk) disable iff (rst)
    pageFault |=> !missPending);

  assert_flush_cancels_R10: assert property (@(posedge clk) disable iff (rst)
    baseWrite |=> !missPending);

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (!missPending && !evictValid));

endmodule

bind tlbAgeLru tlbChecker #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lookupValid(lookupValid),
  .lookupVaddr(lookupVaddr),
  .lookupReady(lookupReady),
  .hit        (hit),
  .paddr      (paddr),
  .protFault  (protFault),
  .pageFault  (pageFault),
  .missPending(missPending),
  .refillValid(refillValid),
  .baseWrite  (baseWrite),
  .evictValid (evictValid)
);

// File: tb/test_tlbAgeLru.sv
`timescale 1ns/1ps
module test_tlbAgeLru;

  logic        clk = 1'b0;
  logic        rst;
  logic        lookupValid, lookupWrite, lookupReady, hit, protFault, pageFault, missPending;
  logic [15:0] lookupVaddr, paddr;
  logic        refillValid, refillCanRead, refillCanWrite, refillPresent, baseWrite;
  logic [7:0]  refillPpn, evictVpn, evictPpn;
  logic        evictValid, evictDirty;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlbAgeLru i_tlbAgeLru (
    .clk(clk), .rst(rst),
    .lookupValid(lookupValid), .lookupVaddr(lookupVaddr), .lookupWrite(lookupWrite),
    .lookupReady(lookupReady), .hit(hit), .paddr(paddr),
    .protFault(protFault), .pageFault(pageFault), .missPending(missPending),
    .refillValid(refillValid), .refillPpn(refillPpn), .refillCanRead(refillCanRead),
    .refillCanWrite(refillCanWrite), .refillPresent(refillPresent),
    .baseWrite(baseWrite),
    .evictValid(evictValid), .evictVpn(evictVpn), .evictPpn(evictPpn), .evictDirty(evictDirty)
  );

  // reference model
  logic [7:0] mVpn [8];
  logic [7:0] mPpn [8];
  logic [2:0] mRank[8];
  logic       mValid[8], mDirty[8], mRd[8], mWr[8];

  function automatic logic [7:0] pagePpn(input logic [7:0] v);  return v ^ 8'hA5; endfunction
  function automatic logic pageRd(input logic [7:0] v);      return (v % 5) != 4; endfunction
  function automatic logic pageWr(input logic [7:0] v);      return (v % 3) != 0; endfunction
  function automatic logic pagePresent(input logic [7:0] v); return (v % 7) != 2; endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < 8; i++) begin
      mValid[i] = 0; mDirty[i] = 0; mRank[i] = 3'd7;
    end
  endtask

  task automatic modelTouch(input int idx, input logic [2:0] k);
    for (int i = 0; i < 8; i++) begin
      if (i == idx) mRank[i] = 3'd0;
      else if (mValid[i] && mRank[i] < k) mRank[i] = mRank[i] + 3'd1;
    end
  endtask

  task automatic doAccess(input logic [7:0] vpn, input logic [7:0] off,
                          input logic wr, input bit probe);
    int idx = -1;
    logic allowed;
    for (int i = 0; i < 8; i++) if (mValid[i] && mVpn[i] == vpn) idx = i;
    @(negedge clk);
    lookupValid = 1; lookupVaddr = {vpn, off}; lookupWrite = wr;
    #0.5;
    if (idx >= 0) begin
      allowed = wr ? mWr[idx] : mRd[idx];
      check(hit == 1'b1, "R2", "hit", 16'(hit), 16'd1);
      check(paddr == {mPpn[idx], off}, "R1", "hit paddr", paddr, {mPpn[idx], off});
      check(protFault == !allowed, "R7", "hit protFault", 16'(protFault), 16'(!allowed));
      @(posedge clk);
      if (allowed) begin
        modelTouch(idx, mRank[idx]);          // R3 age update
        if (wr) mDirty[idx] = 1;              // R6
      end
    end else begin
      int victim = -1;
      logic expEv, expDirty;
      logic [7:0] expVpn, expPpn;
      logic [2:0] k;
      logic pres;
      check(hit == 1'b0, "R2", "miss", 16'(hit), 16'd0);
      @(posedge clk);
      @(negedge clk);
      lookupValid = 0;
      #0.5;
      check(missPending == 1'b1 && lookupReady == 1'b0, "R9", "pending after miss",
            {14'd0, missPending, lookupReady}, 16'd2);
      if (probe) begin
        for (int i = 0; i < 8; i++) if (mValid[i]) begin
          lookupValid = 1; lookupVaddr = {mVpn[i], 8'h3C}; lookupWrite = 1;
          #0.5;
          check(hit == 1'b0, "R9", "lookup while pending", 16'(hit), 16'd0);
          lookupValid = 0;
          break;
        end
      end
      pres = pagePresent(vpn);
      refillValid = 1; refillPpn = pagePpn(vpn);
      refillCanRead = pageRd(vpn); refillCanWrite = pageWr(vpn); refillPresent = pres;
      #0.5;
      allowed = wr ? pageWr(vpn) : pageRd(vpn);
      if (!pres) begin
        check(pageFault == 1'b1 && protFault == 1'b0, "R8", "page fault",
              {14'd0, pageFault, protFault}, 16'd2);
      end else begin
        check(pageFault == 1'b0, "R8", "no page fault", 16'(pageFault), 16'd0);
        check(paddr == {pagePpn(vpn), off}, "R1", "refill paddr", paddr, {pagePpn(vpn), off});
        check(protFault == !allowed, "R7", "refill protFault", 16'(protFault), 16'(!allowed));
      end
      @(posedge clk);
      expEv = 0; expVpn = 0; expPpn = 0; expDirty = 0;
      if (pres) begin
        for (int i = 7; i >= 0; i--) if (!mValid[i]) victim = i;
        if (victim < 0) begin
          for (int i = 0; i < 8; i++) if (mRank[i] == 3'd7) victim = i;
          expEv = 1; expVpn = mVpn[victim]; expPpn = mPpn[victim]; expDirty = mDirty[victim];
        end
        k = mRank[victim];
        mVpn[victim] = vpn; mPpn[victim] = pagePpn(vpn);
        mRd[victim] = pageRd(vpn); mWr[victim] = pageWr(vpn);
        mValid[victim] = 1; mDirty[victim] = wr && pageWr(vpn);
        modelTouch(victim, k);
      end
      @(negedge clk);
      refillValid = 0;
      #0.5;
      check(missPending == 1'b0, "R8", "miss ended", 16'(missPending), 16'd0);
      check(evictValid == expEv, expEv ? "R5" : "R4", "evictValid", 16'(evictValid), 16'(expEv));
      if (expEv && evictValid) begin
        check(evictVpn == expVpn, "R3", "victim vpn", 16'(evictVpn), 16'(expVpn));
        check(evictPpn == expPpn, "R5", "victim ppn", 16'(evictPpn), 16'(expPpn));
        check(evictDirty == expDirty, "R6", "victim dirty", 16'(evictDirty), 16'(expDirty));
      end
    end
  endtask

  task automatic doFlush();
    @(negedge clk);
    lookupValid = 0; baseWrite = 1;
    @(posedge clk);
    modelClear();
    @(negedge clk);
    baseWrite = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    rst = 1; lookupValid = 0; lookupVaddr = 0; lookupWrite = 0;
    refillValid = 0; refillPpn = 0; refillCanRead = 0; refillCanWrite = 0;
    refillPresent = 0; baseWrite = 0;
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #0.5;
    check(missPending == 0 && lookupReady == 1 && evictValid == 0 && hit == 0, "R11",
          "reset state", {12'd0, missPending, lookupReady, evictValid, hit}, 16'h4);

    // R2 R3 R4 R5 R6 R7: random stream over 12 pages
    for (int n = 0; n < 600; n++) begin
      logic [7:0] v;
      seed = seed * 32'd1103515245 + 32'd12345;
      v = 8'(((seed >> 16) % 12) * 19 + 1);
      doAccess(v, seed[7:0], seed[9], n % 50 == 7);
    end

    // R10: flush, then previously cached pages miss
    doFlush();
    doAccess(8'd1, 8'h10, 1'b0, 0);

    // R10: flush cancels a pending miss; stray refill has no effect
    @(negedge clk);
    lookupValid = 1; lookupVaddr = 16'hF142; lookupWrite = 0;
    @(posedge clk);
    @(negedge clk);
    lookupValid = 0;
    #0.5;
    check(missPending == 1, "R9", "pending before flush", 16'(missPending), 16'd1);
    baseWrite = 1;
    @(posedge clk);
    modelClear();
    @(negedge clk);
    baseWrite = 0;
    #0.5;
    check(missPending == 0 && lookupReady == 1, "R10", "flush cancels miss",
          {14'd0, missPending, lookupReady}, 16'd1);
    refillValid = 1; refillPpn = 8'h77; refillCanRead = 1; refillCanWrite = 1; refillPresent = 0;
    #0.5;
    check(pageFault == 0 && protFault == 0, "R10", "stray refill ignored",
          {14'd0, pageFault, protFault}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    refillValid = 0;
    #0.5;
    check(evictValid == 0, "R10", "no eviction from stray refill", 16'(evictValid), 16'd0);
    doAccess(8'hF1, 8'h42, 1'b1, 0);
    doAccess(8'hF1, 8'h99, 1'b0, 0);

    // second random stream after flush
    for (int n = 0; n < 300; n++) begin
      logic [7:0] v;
      seed = seed * 32'd1103515245 + 32'd12345;
      v = 8'(((seed >> 16) % 11) * 23 + 2);
      doAccess(v, seed[7:0], seed[10], n % 40 == 3);
    end

    @(negedge clk);
    lookupValid = 0;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule